// File: doc/BRIEF.md
# Retransmit FIFO with Half-Full Status

A single-clock first-in/first-out buffer for 9-bit words, with a power-of-two depth set by a parameter. Writes and reads are requested by separate strobes and may both be accepted in the same clock cycle. No address is supplied: a write pointer and a read pointer, each one bit wider than the storage address, step forward on every accepted access.

Three registered status flags report empty, full and more-than-half-full occupancy. Read data is registered and comes with a valid qualifier, which is high only in the cycle after an accepted read. A rewind input, honoured only while both strobes are idle, moves the read pointer back to location zero so that the words written since reset can be read out again. The write pointer and the stored words are not changed, and the flags are recomputed from the new pointer distance.

Top module: `rtfifo`

## Requirements
- R1: In the cycle after a synchronous reset (rst high), empty is 1, full is 0, half_full is 0 and rd_valid is 0; both pointers are at location zero.
- R2: Words are read out in the order in which they were accepted. The data appears on rd_data in the clock cycle after the accepted read. Empty and full are never both 1.
- R3: With no reads after reset, full rises after exactly DEPTH accepted writes and not earlier. A write request while full is dropped and does not overwrite any stored word.
- R4: A read request while empty is ignored: rd_valid stays 0, empty stays 1 and the next written word is the next word read.
- R5: The first accepted read after the buffer is full clears full in the same update.
- R6: half_full is 1 exactly when occupancy is greater than DEPTH/2. It rises on the write that takes occupancy to DEPTH/2+1 and falls on the read that brings occupancy to DEPTH/2.
- R7: A rewind pulse with wr_en and rd_en both low sets the read pointer to location zero. The following reads replay from the first word written after reset. The write pointer is unchanged, so later writes follow the words already stored.
- R8: A rewind request in a cycle in which wr_en or rd_en is high is ignored; only the normal write or read takes place.
- R9: A read and a write accepted in the same cycle on a buffer that is neither empty nor full leave occupancy, empty and full unchanged.
- R10: After an accepted rewind, empty, full and half_full reflect the distance between the write pointer and location zero.
- R11: rd_valid is 1 in a cycle exactly when a read was accepted in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request strobe |
| wr_data | input | 9 | Word to store on an accepted write |
| rd_en | input | 1 | Read request strobe |
| rewind | input | 1 | Request to return the read pointer to location zero |
| rd_data | output | 9 | Registered word from the last accepted read |
| rd_valid | output | 1 | High when rd_data holds a word from the previous cycle's accepted read |
| empty | output | 1 | Registered flag: no words held |
| full | output | 1 | Registered flag: DEPTH words held |
| half_full | output | 1 | Registered flag: more than DEPTH/2 words held |

## Verification
The bench runs the main storage path with four patterns. A short write burst followed by a drain checks ordering. A fill to capacity followed by a full drain places every flag edge at an exact occupancy. Interleaved simultaneous read and write cycles catch a pointer that stalls or double-steps under a concurrent access. Reads against an empty buffer and writes against a full one show whether a refused request leaks into the pointers or into memory. Two rewind sequences, one with idle strobes and one with a strobe active, tell a correct rewind apart from one that also moves the write side or that ignores the idle condition.

// File: rtl/rtfifo_pkg.sv
package rtfifo_pkg;
  localparam int WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/rtfifo_ctrl.sv
module rtfifo_ctrl #(
  parameter int DEPTH = 512
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_req,
  input  logic                         rd_req,
  input  logic                         rewind_req,
  output logic                         wr_acc,
  output logic                         rd_acc,
  output logic [$clog2(DEPTH)-1:0]     waddr,
  output logic [$clog2(DEPTH)-1:0]     raddr,
  output logic                         empty,
  output logic                         full,
  output logic                         half_full
);
  localparam int AW   = $clog2(DEPTH);
  localparam int PW   = AW + 1;
  localparam int HALF = DEPTH / 2;

  logic [PW-1:0] wptr, rptr;
  logic [PW-1:0] wptr_n, rptr_n, occ_n;
  logic          rt_acc;

  assign wr_acc = wr_req && !full;
  assign rd_acc = rd_req && !empty;
  assign rt_acc = rewind_req && !wr_req && !rd_req;

  assign waddr = wptr[AW-1:0];
  assign raddr = rptr[AW-1:0];

  always_comb begin
    wptr_n = wptr + PW'(wr_acc);
    rptr_n = rt_acc ? '0 : rptr + PW'(rd_acc);
    occ_n  = wptr_n - rptr_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      empty     <= 1'b1;
      full      <= 1'b0;
      half_full <= 1'b0;
    end else begin
      wptr      <= wptr_n;
      rptr      <= rptr_n;
      empty     <= (occ_n == '0);
      full      <= (occ_n == PW'(DEPTH));
      half_full <= (occ_n > PW'(HALF));
    end
  end

  // R1
  rst_flags_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (empty && !full && !half_full && wptr == '0 && rptr == '0));

  // R2
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    PW'(wptr - rptr) <= PW'(DEPTH));

  // R4
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_req && !wr_req && !rewind_req) |=> (empty && $stable(rptr)));

  // R7
  rewind_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    (rewind_req && !wr_req && !rd_req) |=> (rptr == '0 && $stable(wptr)));

  // R9
  simul_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (!empty && !full && wr_req && rd_req && !rewind_req) |=> ($stable(empty) && $stable(full)));
endmodule

// File: rtl/rtfifo_mem.sv
module rtfifo_mem #(
  parameter int DEPTH = 512,
  parameter int W     = 9
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata,
  output logic                     rvalid
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= re;
  end
endmodule

// File: rtl/rtfifo.sv
module rtfifo #(
  parameter int DEPTH = 512
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [rtfifo_pkg::WORD_W-1:0] wr_data,
  input  logic                          rd_en,
  input  logic                          rewind,
  output logic [rtfifo_pkg::WORD_W-1:0] rd_data,
  output logic                          rd_valid,
  output logic                          empty,
  output logic                          full,
  output logic                          half_full
);
  import rtfifo_pkg::*;
  localparam int AW = $clog2(DEPTH);

  logic          wr_acc, rd_acc;
  logic [AW-1:0] waddr, raddr;
  word_t         q;

  rtfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .wr_req(wr_en), .rd_req(rd_en), .rewind_req(rewind),
    .wr_acc(wr_acc), .rd_acc(rd_acc), .waddr(waddr), .raddr(raddr),
    .empty(empty), .full(full), .half_full(half_full)
  );

  rtfifo_mem #(.DEPTH(DEPTH), .W(WORD_W)) u_mem (
    .clk(clk), .rst(rst), .we(wr_acc), .waddr(waddr), .wdata(wr_data),
    .re(rd_acc), .raddr(raddr), .rdata(q), .rvalid(rd_valid)
  );

  assign rd_data = q;

  // R11
  valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));
endmodule

// File: tb/tb_rtfifo.sv
module tb_rtfifo;
  localparam int DEPTH = 16;
  localparam int HALF  = DEPTH / 2;

  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en, rd_en, rewind;
  logic [8:0] wr_data;
  logic [8:0] rd_data;
  logic       rd_valid, empty, full, half_full;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rtfifo #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rewind(rewind), .rd_data(rd_data), .rd_valid(rd_valid),
    .empty(empty), .full(full), .half_full(half_full)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive just after an edge, sample just after the next edge
  task automatic cyc(input logic w, input int d, input logic r, input logic rt);
    wr_en = w; wr_data = 9'(d); rd_en = r; rewind = rt;
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0; rewind = 0;
  endtask

  task automatic do_reset();
    rst = 1; wr_en = 0; rd_en = 0; rewind = 0; wr_data = '0;
    repeat (2) @(posedge clk);
    #1 rst = 0;
  endtask

  task automatic read_expect(input string req, input int exp);
    cyc(0, 0, 1, 0);
    chk({req, " valid"}, int'(rd_valid), 1);
    chk({req, " data"}, int'(rd_data), exp);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 half", int'(half_full), 0);
    chk("R1 valid", int'(rd_valid), 0);
  endtask

  task automatic t_order();
    do_reset();
    for (int i = 0; i < 5; i++) cyc(1, 'h1A0 + i, 0, 0);
    chk("R11 no valid after write", int'(rd_valid), 0);
    for (int i = 0; i < 5; i++) read_expect("R2 order", 'h1A0 + i);
    chk("R2 empty after drain", int'(empty), 1);
    cyc(0, 0, 0, 0);
    chk("R11 valid drops", int'(rd_valid), 0);
  endtask

  task automatic t_empty_read();
    do_reset();
    cyc(0, 0, 1, 0);
    chk("R4 no valid", int'(rd_valid), 0);
    chk("R4 still empty", int'(empty), 1);
    cyc(0, 0, 1, 0);
    chk("R4 no valid twice", int'(rd_valid), 0);
    cyc(1, 'h055, 0, 0);
    chk("R4 not empty", int'(empty), 0);
    read_expect("R4 next word", 'h055);
  endtask

  task automatic t_fill();
    int occ = 0;
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1, 'h040 + i, 0, 0);
      occ++;
      chk("R3 full edge", int'(full), int'(occ == DEPTH));
      chk("R6 half rise", int'(half_full), int'(occ > HALF));
    end
    cyc(1, 'h1FF, 0, 0);
    chk("R3 still full", int'(full), 1);
    for (int i = 0; i < DEPTH; i++) begin
      read_expect("R3 no overwrite", 'h040 + i);
      occ--;
      if (i == 0) chk("R5 full cleared", int'(full), 0);
      chk("R6 half fall", int'(half_full), int'(occ > HALF));
      chk("R2 empty edge", int'(empty), int'(occ == 0));
    end
  endtask

  task automatic t_simul();
    do_reset();
    for (int i = 0; i < 3; i++) cyc(1, 'h0C0 + i, 0, 0);
    for (int i = 0; i < 4; i++) begin
      cyc(1, 'h0D0 + i, 1, 0);
      chk("R9 data", int'(rd_data), i < 3 ? 'h0C0 + i : 'h0D0 + i - 3);
      chk("R9 empty", int'(empty), 0);
      chk("R9 full", int'(full), 0);
    end
    read_expect("R9 occ held", 'h0D1);
    read_expect("R9 occ held", 'h0D2);
    read_expect("R9 occ held", 'h0D3);
    chk("R9 drained", int'(empty), 1);
  endtask

  task automatic t_rewind();
    do_reset();
    for (int i = 0; i < 10; i++) cyc(1, 'h100 + i, 0, 0);
    for (int i = 0; i < 10; i++) read_expect("R7 first pass", 'h100 + i);
    chk("R7 empty before", int'(empty), 1);
    cyc(0, 0, 0, 1);
    chk("R10 empty after rewind", int'(empty), 0);
    chk("R10 half after rewind", int'(half_full), 1);
    chk("R10 full after rewind", int'(full), 0);
    read_expect("R7 replay start", 'h100);
    cyc(1, 'h0AB, 0, 0);
    cyc(0, 0, 0, 1);
    for (int i = 0; i < 10; i++) read_expect("R7 replay", 'h100 + i);
    read_expect("R7 write ptr kept", 'h0AB);
    chk("R7 empty end", int'(empty), 1);
  endtask

  task automatic t_rewind_blocked();
    do_reset();
    for (int i = 0; i < 3; i++) cyc(1, 'h020 + i, 0, 0);
    read_expect("R8 setup", 'h020);
    cyc(0, 0, 1, 1);
    chk("R8 rewind with read", int'(rd_data), 'h021);
    cyc(1, 'h023, 0, 1);
    read_expect("R8 rewind with write", 'h022);
    read_expect("R8 write kept", 'h023);
    chk("R8 empty", int'(empty), 1);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_order();
    t_empty_read();
    t_fill();
    t_simul();
    t_rewind();
    t_rewind_blocked();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule